// File: doc/BRIEF.md
# Watchdog Timer with Control Register

The block guards a processor against runaway software. A divide-by-twelve tick generator drives an 8-bit prescaler. A selectable tap of the prescaler advances an overflow counter, which is 15 bits wide by default. When that counter wraps, the block raises a reset request for the processor and sets a sticky overflow flag. Software must write the restart bit often enough to keep the counter from wrapping.

All control goes through one 8-bit register. The register holds a set-only enable bit, a restart bit that clears itself, an idle-run bit, a 3-bit tap select and the overflow flag. The enable bit, the idle-run bit and the tap select take their power-on values from a preset input, so a watchdog that is enabled at power-on starts counting straight out of reset. The overflow flag and the enable bit survive the block's own reset request. Only the power-on reset clears them.

Top module: `wdt_top`

## Requirements
- R1: While `rst_ni` is low, the read data becomes {0, 0, preset[5], 0, preset[3], preset[2:0]} and `wdt_req_o` is 0. Preset bits 7, 6 and 4 are ignored.
- R2: The register layout is: bit 7 flag, bit 6 unused, bit 5 enable, bit 4 restart, bit 3 idle-run, bits 2:0 tap select. A write that sets the enable bit starts counting. `wdt_req_o` first goes high exactly TICK_DIV * 2^(sel+1) * 2^CNT_W clock edges after the write edge, where sel=0 divides by 2 and sel=7 divides by 256.
- R3: Each overflow gives a `wdt_req_o` pulse of exactly REQ_LEN (4) cycles. Counting then restarts from zero, so the next overflow follows one full period later.
- R4: An overflow sets read bit 7. Writing 0 to bit 7 clears the flag. Writing 1 to bit 7 leaves it unchanged.
- R5: Once the enable bit is 1, writing 0 to bit 5 neither clears it nor stops counting.
- R6: Writing 1 to bit 4 clears the tick divider, the prescaler and the counter, so the full period restarts from that write edge. Bit 4 always reads 0.
- R7: With idle-run at 0, counting is frozen while `idle_i` is high, and the overflow is delayed by exactly the number of frozen cycles. With idle-run at 1, `idle_i` has no effect.
- R8: While the enable bit is 0, no counting takes place and `wdt_req_o` stays low.
- R9: With preset bit 5 set, counting starts at the first clock edge after reset release, and the first request comes one full period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| wr_i | input | 1 | Control register write strobe |
| wdata_i | input | 8 | Control register write data |
| idle_i | input | 1 | Processor idle-mode indication |
| preset_i | input | 8 | Register values loaded during power-on reset |
| rdata_o | output | 8 | Control register read data |
| wdt_req_o | output | 1 | Reset request pulse to the processor |

## Verification
The assertions take for granted that `wdt_req_o` never falls within five cycles of reset release. They also assume that the pause check applies only when no write is in flight, because a restart write may legitimately clear a frozen counter. The stimulus drives the write strobe for exactly one clock and changes `idle_i` only on falling edges. It lets each overflow be reached with `preset_i` held steady. The bench shortens the counter to 4 bits so that whole periods fit in the run while every tap is still derived from the same formula.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W    = 8;
  localparam int SEL_W    = 3;
  localparam int B_FLAG   = 7;
  localparam int B_EN     = 5;
  localparam int B_RESTRT = 4;
  localparam int B_IDLE   = 3;

  typedef struct packed {
    logic             en;
    logic             idle_run;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (tick_o)        cnt_q <= '0;
    else if (run_i)         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int W     = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tap_o,
  output logic [W-1:0]     pre_o
);
  logic [W-1:0] pre_q;
  logic [W-1:0] full;

  // tap g fires once every 2^(g+1) ticks
  for (genvar g = 0; g < W; g++) begin : g_tap
    assign full[g] = &pre_q[g:0];
  end

  assign tap_o = tick_i && full[sel_i];
  assign pre_o = pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_i) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_ovf_cnt.sv
module wdt_ovf_cnt #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic         ovf_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  assign ovf_o = step_i && (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] preset_i,
  input  logic             ovf_i,
  output wdt_cfg_t         cfg_o,
  output logic             restart_o,
  output logic [REG_W-1:0] rdata_o
);
  wdt_cfg_t cfg_q;
  logic     flag_q;
  logic     unused_bits;

  assign unused_bits = ^{wdata_i[6], preset_i[7:6], preset_i[4]};

  assign restart_o = wr_i && wdata_i[B_RESTRT];
  assign cfg_o     = cfg_q;
  assign rdata_o   = {flag_q, 1'b0, cfg_q.en, 1'b0, cfg_q.idle_run, cfg_q.sel};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.en       <= preset_i[B_EN];
      cfg_q.idle_run <= preset_i[B_IDLE];
      cfg_q.sel      <= preset_i[SEL_W-1:0];
    end else if (wr_i) begin
      cfg_q.en       <= cfg_q.en | wdata_i[B_EN];
      cfg_q.idle_run <= wdata_i[B_IDLE];
      cfg_q.sel      <= wdata_i[SEL_W-1:0];
    end
  end

  // overflow wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         flag_q <= 1'b0;
    else if (ovf_i)                      flag_q <= 1'b1;
    else if (wr_i && !wdata_i[B_FLAG])   flag_q <= 1'b0;
  end

  assert_en_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.en |=> cfg_q.en);

  assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> rdata_o[B_FLAG]);

  assert_flag_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_i && !wdata_i[B_FLAG])) |=> flag_q);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int TICK_DIV = 12,
  parameter int PRE_W    = 8,
  parameter int CNT_W    = 15,
  parameter int REQ_LEN  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             idle_i,
  input  logic [REG_W-1:0] preset_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             wdt_req_o
);
  localparam int RW = $clog2(REQ_LEN + 1);

  wdt_cfg_t          cfg;
  logic              restart;
  logic              run;
  logic              clr;
  logic              tick;
  logic              tap;
  logic              ovf;
  logic [PRE_W-1:0]  pre;
  logic [CNT_W-1:0]  cnt;
  logic [RW-1:0]     req_cnt_q;

  assign run = cfg.en && (!idle_i || cfg.idle_run);
  assign clr = restart || ovf || !cfg.en;

  wdt_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .preset_i  (preset_i),
    .ovf_i     (ovf),
    .cfg_o     (cfg),
    .restart_o (restart),
    .rdata_o   (rdata_o)
  );

  wdt_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .run_i  (run),
    .tick_o (tick)
  );

  wdt_prescale #(.W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .tick_i (tick),
    .sel_i  (cfg.sel),
    .tap_o  (tap),
    .pre_o  (pre)
  );

  wdt_ovf_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (tap),
    .ovf_o  (ovf),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             req_cnt_q <= '0;
    else if (ovf)            req_cnt_q <= RW'(REQ_LEN);
    else if (req_cnt_q != 0) req_cnt_q <= req_cnt_q - 1'b1;
  end

  assign wdt_req_o = (req_cnt_q != '0);

  assert_ovf_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> wdt_req_o);

  assert_ovf_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> (cnt == '0 && pre == '0));

  assert_req_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdt_req_o) |-> $past(wdt_req_o, 4));

  assert_idle_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.en && idle_i && !cfg.idle_run && !wr_i) |=> ($stable(cnt) && $stable(pre)));

  assert_off_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.en |=> (cnt == '0 && !ovf));

  assert_restart_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (cnt == '0 && pre == '0));
endmodule

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  localparam int CNT_W = 4;
  localparam int DIV   = 12;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       wr_i;
  logic [7:0] wdata_i;
  logic       idle_i;
  logic [7:0] preset_i;
  logic [7:0] rdata_o;
  logic       wdt_req_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  wdt_top #(.TICK_DIV(DIV), .CNT_W(CNT_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .idle_i    (idle_i),
    .preset_i  (preset_i),
    .rdata_o   (rdata_o),
    .wdt_req_o (wdt_req_o)
  );

  function automatic int period(input int sel);
    return DIV * (2 << sel) * (1 << CNT_W);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // caller sits at a falling edge; returns at the falling edge after the write edge
  task automatic reg_wr(input logic [7:0] d);
    wr_i = 1'b1;
    wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic expect_req_at(input int n, input string tag);
    repeat (n - 1) @(negedge clk);
    chk(tag, {7'd0, wdt_req_o}, 8'd0);
    @(negedge clk);
    chk(tag, {7'd0, wdt_req_o}, 8'd1);
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata_o, 8'h0B);
    chk("R1 req", {7'd0, wdt_req_o}, 8'd0);
  endtask

  task automatic t_disabled;
    repeat (2000) @(negedge clk);
    chk("R8 req", {7'd0, wdt_req_o}, 8'd0);
    chk("R8 rdata", rdata_o, 8'h0B);
  endtask

  task automatic t_timeout;
    reg_wr(8'h20);
    expect_req_at(period(0), "R2 first overflow");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 pulse high", {7'd0, wdt_req_o}, 8'd1);
    end
    @(negedge clk);
    chk("R3 pulse end", {7'd0, wdt_req_o}, 8'd0);
    chk("R4 flag set", rdata_o, 8'hA0);
    expect_req_at(period(0) - 4, "R3 second overflow");
  endtask

  task automatic t_flag;
    reg_wr(8'hA0);
    chk("R4 write one keeps", rdata_o, 8'hA0);
    reg_wr(8'h20);
    chk("R4 write zero clears", rdata_o, 8'h20);
  endtask

  task automatic t_sticky;
    reg_wr(8'h10);
    chk("R5 enable kept", rdata_o, 8'h20);
    expect_req_at(period(0), "R5 still counting");
  endtask

  task automatic t_restart;
    reg_wr(8'h31);
    chk("R6 restart reads 0", rdata_o, 8'h21);
    repeat (500) @(negedge clk);
    chk("R6 no early req", {7'd0, wdt_req_o}, 8'd0);
    reg_wr(8'h31);
    expect_req_at(period(1), "R6 period from restart");
  endtask

  task automatic t_idle;
    reg_wr(8'h30);
    repeat (100) @(negedge clk);
    idle_i = 1'b1;
    repeat (200) @(negedge clk);
    idle_i = 1'b0;
    expect_req_at(period(0) + 200 - 300, "R7 frozen in idle");
    idle_i = 1'b1;
    reg_wr(8'h38);
    expect_req_at(period(0), "R7 idle-run counts");
    idle_i = 1'b0;
  endtask

  task automatic t_preset;
    rst_ni = 1'b0;
    preset_i = 8'h21;
    @(negedge clk);
    rst_ni = 1'b1;
    chk("R9 preset rdata", rdata_o, 8'h21);
    expect_req_at(period(1), "R9 counts from reset");
  endtask

  initial begin
    rst_ni = 1'b0;
    wr_i = 1'b0;
    wdata_i = 8'h00;
    idle_i = 1'b0;
    preset_i = 8'hDB;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_timeout();
    t_flag();
    t_sticky();
    t_restart();
    t_idle();
    t_preset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule